// File: doc/BRIEF.md
# Status Register Transfer Unit

This block executes the instructions that copy a status word into or out of a banked-mode processor's two status registers: the current status register and the saved status register. The saved register belongs to the active mode. The decoder supplies a transfer request. It states the direction (read or write) and the target (current or saved). It states whether only the flag nibble is written. For flag writes, it states whether an 8-bit rotated immediate or the source register supplies the value. The datapath supplies the source register value, both status words and the outcome of the condition check. The active mode is the low five bits of the current status word.

One cycle after an accepted request, the unit presents exactly one of four results as a registered pulse: a write enable with data for the current register, a write enable with data for the saved register, a write enable with data for the destination register, or an illegal-access flag. An illegal access produces no write at all. The unit checks privilege and mode validity. A flag-only write replaces bits 31:28 and carries the rest of the target word over unchanged.

Top module: `psr_xfer_unit`

## Requirements
- R1: A request whose condition input is low, or a cycle without a request, produces no enable and no exception on the next cycle.
- R2: Any read or write of the saved register while the mode field is User (10000) or System (11111) raises the exception and writes nothing.
- R3: A flag-only write produces the value's bits 31:28 over the target register's bits 27:0 taken unchanged, and it never checks the mode.
- R4: When a flag-only write selects the immediate, the value is the 8-bit immediate zero-extended to 32 bits and rotated right by twice the 4-bit rotate field.
- R5: A full write always takes the source register. If bits 4:0 of the source register are not one of 10000, 10001, 10010, 10011, 10111, 11011 or 11111, it raises the exception and writes nothing.
- R6: In User mode, a full write to the current register that changes the mode field raises the exception unless the mode-switch permit input is high. A write that keeps the same mode field is accepted.
- R7: A read enables the destination register write and places the selected status register on its data output.
- R8: Every result appears as a single-cycle pulse on the cycle after the request. At most one of the four result outputs is high in any cycle, and all of them are low during and right after reset.
- R9: An accepted full write places the whole source value on the target register's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request present |
| cond_pass_i | input | 1 | Condition check passed |
| write_i | input | 1 | 1 = write a status register, 0 = read one |
| saved_i | input | 1 | 1 = saved register, 0 = current register |
| flags_only_i | input | 1 | Write bits 31:28 only |
| use_imm_i | input | 1 | Flag write takes the rotated immediate |
| imm_i | input | 8 | Immediate byte |
| rot_i | input | 4 | Rotate field; the rotation is twice this value |
| src_i | input | 32 | Source register value |
| cur_psr_i | input | 32 | Current status word (bits 4:0 give the mode) |
| sav_psr_i | input | 32 | Saved status word of the active mode |
| user_mode_sw_ok_i | input | 1 | Allows mode changes from User mode |
| cur_we_o | output | 1 | Current register write enable |
| cur_wdata_o | output | 32 | Current register write data |
| sav_we_o | output | 1 | Saved register write enable |
| sav_wdata_o | output | 32 | Saved register write data |
| rd_we_o | output | 1 | Destination register write enable |
| rd_wdata_o | output | 32 | Destination register write data |
| exc_o | output | 1 | Illegal access flag |

## Verification
Every result is registered only once, so a wrong decision shows at the ports on the cycle after the request. Examples are a missed privilege check, a mis-merged flag nibble or a rotation off by one step. Such a fault appears as a wrong enable or a wrong data word, and it cannot hide behind later traffic. The sweeps cover every legal mode against all 32 values of the source mode field, every rotate amount and both targets. Any wrong pairing of mode and permission therefore flips an enable that the bench compares on that same cycle.

// File: rtl/psr_xfer_pkg.sv
package psr_xfer_pkg;
  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef struct packed {
    logic write;
    logic saved;
    logic flags_only;
    logic use_imm;
  } xfer_req_t;

  function automatic logic mode_is_valid(logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic mode_has_saved(logic [MODE_W-1:0] m);
    return mode_is_valid(m) && (m != MODE_USR) && (m != MODE_SYS);
  endfunction
endpackage

// File: rtl/psr_imm_rot.sv
module psr_imm_rot #(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 8,
  parameter int ROT_W    = 4,
  parameter int ROT_STEP = 2
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [ROT_W-1:0] rot_i,
  output logic [XLEN-1:0]  val_o
);
  localparam int NROT = 1 << ROT_W;

  logic [XLEN-1:0] ext;
  logic [XLEN-1:0] cand [NROT];

  assign ext = XLEN'(imm_i);

  for (genvar k = 0; k < NROT; k++) begin : g_rot
    localparam int SH = (ROT_STEP * k) % XLEN;
    if (SH == 0) begin : g_zero
      assign cand[k] = ext;
    end else begin : g_shift
      assign cand[k] = (ext >> SH) | (ext << (XLEN - SH));
    end
  end

  assign val_o = cand[rot_i];
endmodule

// File: rtl/psr_access_check.sv
module psr_access_check
  import psr_xfer_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [MODE_W-1:0] src_mode_i,
  input  xfer_req_t         req_i,
  input  logic              sw_ok_i,
  output logic              exc_o
);
  logic full_wr, saved_bad, bad_mode, user_sw;

  always_comb begin
    full_wr   = req_i.write & ~req_i.flags_only;
    saved_bad = req_i.saved & ~mode_has_saved(mode_i);
    bad_mode  = full_wr & ~mode_is_valid(src_mode_i);
    user_sw   = full_wr & ~req_i.saved & (mode_i == MODE_USR)
              & (src_mode_i != mode_i) & ~sw_ok_i;
    exc_o     = saved_bad | bad_mode | user_sw;
  end
endmodule

// File: rtl/psr_wdata_mux.sv
module psr_wdata_mux
  import psr_xfer_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 4
) (
  input  xfer_req_t       req_i,
  input  logic [XLEN-1:0] imm_val_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] cur_psr_i,
  input  logic [XLEN-1:0] sav_psr_i,
  output logic [XLEN-1:0] wdata_o,
  output logic [XLEN-1:0] rdata_o
);
  localparam int KEEP_W = XLEN - FLAG_W;

  logic [XLEN-1:0] target, flag_src;

  always_comb begin
    target   = req_i.saved ? sav_psr_i : cur_psr_i;
    flag_src = req_i.use_imm ? imm_val_i : src_i;
    wdata_o  = req_i.flags_only ? {flag_src[XLEN-1 -: FLAG_W], target[KEEP_W-1:0]}
                                : src_i;
    rdata_o  = target;
  end
endmodule

// File: rtl/psr_xfer_unit.sv
module psr_xfer_unit
  import psr_xfer_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 4,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             cond_pass_i,
  input  logic             write_i,
  input  logic             saved_i,
  input  logic             flags_only_i,
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [ROT_W-1:0] rot_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [XLEN-1:0]  cur_psr_i,
  input  logic [XLEN-1:0]  sav_psr_i,
  input  logic             user_mode_sw_ok_i,
  output logic             cur_we_o,
  output logic [XLEN-1:0]  cur_wdata_o,
  output logic             sav_we_o,
  output logic [XLEN-1:0]  sav_wdata_o,
  output logic             rd_we_o,
  output logic [XLEN-1:0]  rd_wdata_o,
  output logic             exc_o
);
  xfer_req_t       req;
  logic [XLEN-1:0] imm_val, wdata, rdata;
  logic            acc_exc, fire, ok;

  assign req = '{write: write_i, saved: saved_i, flags_only: flags_only_i, use_imm: use_imm_i};

  psr_imm_rot #(.XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W), .ROT_STEP(2)) u_rot (
    .imm_i (imm_i),
    .rot_i (rot_i),
    .val_o (imm_val)
  );

  psr_access_check u_chk_acc (
    .mode_i     (cur_psr_i[MODE_W-1:0]),
    .src_mode_i (src_i[MODE_W-1:0]),
    .req_i      (req),
    .sw_ok_i    (user_mode_sw_ok_i),
    .exc_o      (acc_exc)
  );

  psr_wdata_mux #(.XLEN(XLEN), .FLAG_W(FLAG_W)) u_mux (
    .req_i     (req),
    .imm_val_i (imm_val),
    .src_i     (src_i),
    .cur_psr_i (cur_psr_i),
    .sav_psr_i (sav_psr_i),
    .wdata_o   (wdata),
    .rdata_o   (rdata)
  );

  assign fire = req_valid_i & cond_pass_i;
  assign ok   = fire & ~acc_exc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_we_o    <= 1'b0;
      sav_we_o    <= 1'b0;
      rd_we_o     <= 1'b0;
      exc_o       <= 1'b0;
      cur_wdata_o <= '0;
      sav_wdata_o <= '0;
      rd_wdata_o  <= '0;
    end else begin
      cur_we_o <= ok & write_i & ~saved_i;
      sav_we_o <= ok & write_i & saved_i;
      rd_we_o  <= ok & ~write_i;
      exc_o    <= fire & acc_exc;
      if (ok & write_i & ~saved_i) cur_wdata_o <= wdata;
      if (ok & write_i & saved_i)  sav_wdata_o <= wdata;
      if (ok & ~write_i)           rd_wdata_o  <= rdata;
    end
  end
endmodule

// File: rtl/psr_xfer_unit_chk.sv
module psr_xfer_unit_chk
  import psr_xfer_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 4,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             cond_pass_i,
  input logic             write_i,
  input logic             saved_i,
  input logic             flags_only_i,
  input logic             use_imm_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [ROT_W-1:0] rot_i,
  input logic [XLEN-1:0]  src_i,
  input logic [XLEN-1:0]  cur_psr_i,
  input logic [XLEN-1:0]  sav_psr_i,
  input logic             user_mode_sw_ok_i,
  input logic             cur_we_o,
  input logic [XLEN-1:0]  cur_wdata_o,
  input logic             sav_we_o,
  input logic [XLEN-1:0]  sav_wdata_o,
  input logic             rd_we_o,
  input logic [XLEN-1:0]  rd_wdata_o,
  input logic             exc_o
);
  localparam int KEEP_W = XLEN - FLAG_W;

  logic fire, any_out;
  assign fire    = req_valid_i & cond_pass_i;
  assign any_out = cur_we_o | sav_we_o | rd_we_o | exc_o;

  p_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !any_out);

  p_saved_nobank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && saved_i && !mode_has_saved(cur_psr_i[MODE_W-1:0])) |=> (exc_o && !cur_we_o && !sav_we_o));

  p_flags_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && write_i && flags_only_i && !saved_i) |=>
      (cur_we_o && cur_wdata_o[KEEP_W-1:0] == $past(cur_psr_i[KEEP_W-1:0])));

  p_mode_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && write_i && !flags_only_i) |=>
      (exc_o || (cur_we_o && mode_is_valid(cur_wdata_o[MODE_W-1:0]))
             || (sav_we_o && mode_is_valid(sav_wdata_o[MODE_W-1:0]))));

  p_user_switch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && write_i && !flags_only_i && !saved_i && !user_mode_sw_ok_i
     && cur_psr_i[MODE_W-1:0] == MODE_USR && src_i[MODE_W-1:0] != MODE_USR) |=> exc_o);

  p_read_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !write_i && !saved_i) |=> (rd_we_o && rd_wdata_o == $past(cur_psr_i)));

  p_one_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cur_we_o, sav_we_o, rd_we_o, exc_o}));

  p_saved_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && write_i && !flags_only_i && saved_i && mode_has_saved(cur_psr_i[MODE_W-1:0])
     && mode_is_valid(src_i[MODE_W-1:0])) |=> (sav_we_o && sav_wdata_o == $past(src_i)));
endmodule

bind psr_xfer_unit psr_xfer_unit_chk #(
  .XLEN(XLEN), .FLAG_W(FLAG_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_psr_xfer_unit_chk (.*);

// File: tb/psr_xfer_unit_bench.sv
module psr_xfer_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, cond_pass_i = 1'b0, write_i = 1'b0, saved_i = 1'b0;
  logic        flags_only_i = 1'b0, use_imm_i = 1'b0, user_mode_sw_ok_i = 1'b0;
  logic [7:0]  imm_i = '0;
  logic [3:0]  rot_i = '0;
  logic [31:0] src_i = '0, cur_psr_i = '0, sav_psr_i = '0;
  logic        cur_we_o, sav_we_o, rd_we_o, exc_o;
  logic [31:0] cur_wdata_o, sav_wdata_o, rd_wdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  psr_xfer_unit u_psr_xfer_unit (.*);

  logic [4:0] modes [7] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};

  function automatic bit legal(logic [4:0] m);
    foreach (modes[i]) if (modes[i] == m) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, logic [131:0] act, logic [131:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a negedge, sample at the next negedge (one register stage).
  task automatic run(bit cond, bit wr, bit sv, bit fl, bit im, logic [7:0] imm,
                     logic [3:0] rot, logic [31:0] src, logic [31:0] cur,
                     logic [31:0] sav, bit swok);
    logic [31:0] tgt, val, rot_val, wd;
    logic [63:0] dbl;
    bit ex, cw, sw, rw;
    string req;
    logic [131:0] act, exp;
    req_valid_i = 1'b1; cond_pass_i = cond; write_i = wr; saved_i = sv;
    flags_only_i = fl; use_imm_i = im; imm_i = imm; rot_i = rot;
    src_i = src; cur_psr_i = cur; sav_psr_i = sav; user_mode_sw_ok_i = swok;
    tgt = sv ? sav : cur;
    dbl = {24'h0, imm, 24'h0, imm} >> (2 * rot);
    rot_val = dbl[31:0];
    val = (fl && im) ? rot_val : src;
    wd = fl ? {val[31:28], tgt[27:0]} : src;
    ex = sv && (cur[4:0] == 5'h10 || cur[4:0] == 5'h1F);
    ex = ex || (wr && !fl && !legal(src[4:0]));
    ex = ex || (wr && !fl && !sv && cur[4:0] == 5'h10 && src[4:0] != 5'h10 && !swok);
    ex = ex && cond;
    cw = cond && !ex && wr && !sv;
    sw = cond && !ex && wr && sv;
    rw = cond && !ex && !wr;
    if (!cond)                           req = "R1";
    else if (sv && cur[4:0] inside {5'h10, 5'h1F}) req = "R2";
    else if (wr && fl && im)             req = "R4";
    else if (wr && fl)                   req = "R3";
    else if (wr && !legal(src[4:0]))     req = "R5";
    else if (wr && !sv && cur[4:0] == 5'h10) req = "R6";
    else if (wr)                         req = "R9";
    else                                 req = "R7";
    @(negedge clk_i);
    req_valid_i = 1'b0;
    act = {cur_we_o, sav_we_o, rd_we_o, exc_o,
           cur_we_o ? cur_wdata_o : 32'h0, sav_we_o ? sav_wdata_o : 32'h0,
           rd_we_o ? rd_wdata_o : 32'h0, 32'h0};
    exp = {cw, sw, rw, ex, cw ? wd : 32'h0, sw ? wd : 32'h0, rw ? tgt : 32'h0, 32'h0};
    check(req, act, exp);
  endtask

  task automatic idle_check;
    @(negedge clk_i);
    check("R8 pulse", {128'h0, cur_we_o, sav_we_o, rd_we_o, exc_o}, 132'h0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    check("R8 reset", {128'h0, cur_we_o, sav_we_o, rd_we_o, exc_o}, 132'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle_check();

    foreach (modes[mi]) begin
      logic [31:0] cur = {4'hA, 23'h1234, modes[mi]};
      logic [31:0] sav = {4'h5, 23'h0ABC, 5'h13};
      // R1: condition failing
      for (int w = 0; w < 2; w++) begin
        for (int s = 0; s < 2; s++) begin
          run(0, w[0], s[0], 0, 0, 8'h0, 4'h0, {4'h3, 23'h0, 5'h11}, cur, sav, 0);
        end
      end
      // R7 / R2: reads
      for (int s = 0; s < 2; s++) begin
        run(1, 0, s[0], 0, 0, 8'h0, 4'h0, 32'h0, cur, sav, 0);
      end
      // R5 / R6 / R9 / R2: full writes over all source mode fields
      for (int s = 0; s < 2; s++) begin
        for (int ok = 0; ok < 2; ok++) begin
          for (int m = 0; m < 32; m++) begin
            run(1, 1, s[0], 0, 0, 8'h0, 4'h0, {4'h9, 23'h7F00F, m[4:0]}, cur, sav, ok[0]);
          end
        end
      end
      // R3: flag writes from the register
      for (int s = 0; s < 2; s++) begin
        for (int f = 0; f < 16; f++) begin
          run(1, 1, s[0], 1, 0, 8'h0, 4'h0, {f[3:0], 28'h0, 5'h0} >> 5 | {f[3:0], 28'h5A5A5A5}, cur, sav, 0);
        end
      end
      // R4: flag writes from rotated immediates
      for (int s = 0; s < 2; s++) begin
        for (int r = 0; r < 16; r++) begin
          run(1, 1, s[0], 1, 1, 8'hF0, r[3:0], 32'h0, cur, sav, 0);
          run(1, 1, s[0], 1, 1, 8'h9C, r[3:0], 32'h0, cur, sav, 0);
          run(1, 1, s[0], 1, 1, 8'h01, r[3:0], 32'hFFFF_FFFF, cur, sav, 0);
        end
      end
      idle_check();
    end

    // R8: back-to-back requests each give their own pulse, then silence
    run(1, 0, 0, 0, 0, 8'h0, 4'h0, 32'h0, 32'h8000_0013, 32'h0, 0);
    run(1, 1, 0, 0, 0, 8'h0, 4'h0, 32'h4000_0011, 32'h8000_0013, 32'h0, 0);
    idle_check();

    // R8: reset in the middle of a pulse clears the outputs
    req_valid_i = 1'b1; cond_pass_i = 1'b1; write_i = 1'b0; saved_i = 1'b0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    check("R8 async reset", {128'h0, cur_we_o, sav_we_o, rd_we_o, exc_o}, 132'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle_check();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule